// File: doc/BRIEF.md
# Deflection Routing Node Controller

This block is the electronic decision logic for a single switching point in a slotted, cylinder-organised packet fabric that resolves contention by deflection. Each slot it sees two candidate packet descriptors, each a valid flag plus a binary destination height. One arrives from the preceding node on the same cylinder (West). The other arrives from the next cylinder further out (North). The node takes at most one of them. It examines the one header bit that belongs to its cylinder level and steers the packet either onward along the same cylinder (East) or one cylinder inward (South).

Two controls link neighbouring nodes. A blocking flag from the inner-side neighbour says whether the inward path is free in this slot. The node drives its own blocking flag toward the outer-cylinder node that competes for the same downstream node. The node has no storage for packets. A packet that cannot go inward is deflected East and tries again two hops later. On the innermost cylinder, packets circulate at a fixed height and leave when they reach their target.

The node position is fixed at elaboration: angle, cylinder level and node height. The outgoing blocking flag is produced combinationally within the slot, so inner levels settle before outer ones. Every routing result is registered once per slot on a slot strobe.

Top module: `defl_node_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, all registered outputs (out_vld, out_dest, sel_east, sel_south, exit_vld, west_acc, north_acc) are zero.
- R2: At most one input is accepted per slot. When west_vld is high, the West packet is accepted (west_acc=1) and North is held off (north_acc=0). north_acc=1 only when North alone is valid.
- R3: On a non-innermost level L (L < HEIGHT_W), the node examines only bit HEIGHT_W-1-L of the destination. The packet requests South when that bit equals the same bit of NODE_HEIGHT, and East otherwise. All other destination bits have no effect.
- R4: South is taken only when ctl_in_block is low in the slot. A packet requesting South while ctl_in_block is high is deflected: sel_east=1 and the destination is unchanged.
- R5: ctl_out_block is high in the same cycle, before the strobe, exactly when the current slot's decision is East. It is low for South, exit or idle.
- R6: On the innermost level (LEVEL == HEIGHT_W), a packet whose full destination equals NODE_HEIGHT raises exit_vld with sel_east=sel_south=out_vld=0. Any other packet circulates East.
- R7: Registered outputs change only in the cycle after a clock edge with slot_stb high. Between strobes they hold their values.
- R8: At most one of sel_east, sel_south and exit_vld is high. out_vld equals sel_east OR sel_south. out_dest carries the accepted packet's destination when out_vld is high, and zero otherwise.
- R9: When neither input is valid, the slot produces no selection, no exit, no accept, and ctl_out_block stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | Slot boundary strobe; outputs are registered on it |
| west_vld | input | 1 | Same-cylinder input descriptor valid |
| west_dest | input | HEIGHT_W | Same-cylinder input destination height |
| north_vld | input | 1 | Outer-cylinder input descriptor valid |
| north_dest | input | HEIGHT_W | Outer-cylinder input destination height |
| ctl_in_block | input | 1 | Blocking flag from the inner neighbour (1 = inward path taken) |
| ctl_out_block | output | 1 | Blocking flag to the outer contender, valid within the slot |
| out_vld | output | 1 | Forwarded descriptor valid |
| out_dest | output | HEIGHT_W | Forwarded descriptor destination height |
| sel_east | output | 1 | Packet forwarded along the same cylinder |
| sel_south | output | 1 | Packet forwarded one cylinder inward |
| exit_vld | output | 1 | Packet leaves the fabric here (innermost level only) |
| west_acc | output | 1 | West descriptor accepted this slot |
| north_acc | output | 1 | North descriptor held off when low |

## Verification
The properties assume that the descriptors and ctl_in_block have settled before each clock edge. They also assume the inner neighbour's flag is a plain level within the slot, and they consider only strobes that arrive while reset is low. The stimulus keeps to this by changing every input on the falling edge and sampling on the next falling edge. Reset is held with all valids low, and strobe-free stretches are mixed in so that holding between slots is exercised. Two nodes share the same stimulus: one on an intermediate level and one on the innermost level. This lets the header-bit choice, deflection under blocking and the exit condition be compared against a behavioural slot model.

// File: rtl/dvn_pkg.sv
package dvn_pkg;

    // Per-slot routing outcome of a node
    typedef enum logic [1:0] {
        RT_IDLE  = 2'd0,
        RT_EAST  = 2'd1,
        RT_SOUTH = 2'd2,
        RT_EXIT  = 2'd3
    } route_e;

    // Registered selection bundle
    typedef struct packed {
        logic east;
        logic south;
        logic leave;
    } sel_t;

    // Destination bit examined on a given level, most significant first
    function automatic int unsigned hdr_bit_pos(int unsigned hw, int unsigned lvl);
        return (lvl < hw) ? (hw - 1 - lvl) : 0;
    endfunction

    function automatic sel_t route_to_sel(route_e r);
        sel_t s;
        s.east  = (r == RT_EAST);
        s.south = (r == RT_SOUTH);
        s.leave = (r == RT_EXIT);
        return s;
    endfunction

endpackage

// File: rtl/dvn_in_select.sv
module dvn_in_select #(
    parameter int HEIGHT_W = 4
) (
    input  logic                w_vld,
    input  logic [HEIGHT_W-1:0] w_dest,
    input  logic                n_vld,
    input  logic [HEIGHT_W-1:0] n_dest,
    output logic                pick_vld,
    output logic [HEIGHT_W-1:0] pick_dest,
    output logic                take_w,
    output logic                take_n
);
    // Same-cylinder traffic wins; outer traffic is held off
    always_comb begin
        take_w    = w_vld;
        take_n    = n_vld && !w_vld;
        pick_vld  = w_vld || n_vld;
        pick_dest = w_vld ? w_dest : (n_vld ? n_dest : '0);
    end
endmodule

// File: rtl/dvn_route_dec.sv
module dvn_route_dec
    import dvn_pkg::*;
#(
    parameter int                  HEIGHT_W    = 4,
    parameter int                  LEVEL       = 1,
    parameter logic [HEIGHT_W-1:0] NODE_HEIGHT = '0
) (
    input  logic                pick_vld,
    input  logic [HEIGHT_W-1:0] pick_dest,
    input  logic                blk_in,
    output route_e              route
);
    localparam int unsigned BIT_POS   = hdr_bit_pos(HEIGHT_W, LEVEL);
    localparam bit          INNERMOST = (LEVEL >= HEIGHT_W);

    generate
        if (INNERMOST) begin : g_last
            // Circulate at fixed height until the target is reached
            always_comb begin
                if (!pick_vld)                   route = RT_IDLE;
                else if (pick_dest == NODE_HEIGHT) route = RT_EXIT;
                else                             route = RT_EAST;
            end
        end else begin : g_mid
            logic want_in;
            assign want_in = (pick_dest[BIT_POS] == NODE_HEIGHT[BIT_POS]);
            always_comb begin
                if (!pick_vld)               route = RT_IDLE;
                else if (want_in && !blk_in) route = RT_SOUTH;
                else                         route = RT_EAST;
            end
        end
    endgenerate
endmodule

// File: rtl/dvn_out_reg.sv
module dvn_out_reg
    import dvn_pkg::*;
#(
    parameter int HEIGHT_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  route_e              route,
    input  logic [HEIGHT_W-1:0] pick_dest,
    input  logic                take_w,
    input  logic                take_n,
    output logic                q_vld,
    output logic [HEIGHT_W-1:0] q_dest,
    output sel_t                q_sel,
    output logic                q_wacc,
    output logic                q_nacc
);
    sel_t nxt_sel;
    logic fwd;

    always_comb begin
        nxt_sel = route_to_sel(route);
        fwd     = nxt_sel.east || nxt_sel.south;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_dest <= '0;
            q_sel  <= '0;
            q_wacc <= 1'b0;
            q_nacc <= 1'b0;
        end else if (stb) begin
            q_vld  <= fwd;
            q_dest <= fwd ? pick_dest : '0;
            q_sel  <= nxt_sel;
            q_wacc <= take_w;
            q_nacc <= take_n;
        end
    end
endmodule

// File: rtl/defl_node_ctrl.sv
module defl_node_ctrl
    import dvn_pkg::*;
#(
    parameter int                  HEIGHT_W    = 4,
    parameter int                  LEVEL       = 1,
    parameter int                  ANGLE       = 0,
    parameter logic [HEIGHT_W-1:0] NODE_HEIGHT = 4'b0110
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                slot_stb,
    input  logic                west_vld,
    input  logic [HEIGHT_W-1:0] west_dest,
    input  logic                north_vld,
    input  logic [HEIGHT_W-1:0] north_dest,
    input  logic                ctl_in_block,
    output logic                ctl_out_block,
    output logic                out_vld,
    output logic [HEIGHT_W-1:0] out_dest,
    output logic                sel_east,
    output logic                sel_south,
    output logic                exit_vld,
    output logic                west_acc,
    output logic                north_acc
);
    // Angle only places the node; the decision does not depend on it
    localparam int NODE_ANGLE = ANGLE;

    logic                pick_vld;
    logic [HEIGHT_W-1:0] pick_dest;
    logic                take_w;
    logic                take_n;
    route_e              route;
    sel_t                q_sel;

    dvn_in_select #(.HEIGHT_W(HEIGHT_W)) u_sel (
        .w_vld    (west_vld),
        .w_dest   (west_dest),
        .n_vld    (north_vld),
        .n_dest   (north_dest),
        .pick_vld (pick_vld),
        .pick_dest(pick_dest),
        .take_w   (take_w),
        .take_n   (take_n)
    );

    dvn_route_dec #(
        .HEIGHT_W   (HEIGHT_W),
        .LEVEL      (LEVEL),
        .NODE_HEIGHT(NODE_HEIGHT)
    ) u_dec (
        .pick_vld (pick_vld),
        .pick_dest(pick_dest),
        .blk_in   (ctl_in_block),
        .route    (route)
    );

    // Same-slot flag so the outer contender can deflect in time
    assign ctl_out_block = (route == RT_EAST);

    dvn_out_reg #(.HEIGHT_W(HEIGHT_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .stb      (slot_stb),
        .route    (route),
        .pick_dest(pick_dest),
        .take_w   (take_w),
        .take_n   (take_n),
        .q_vld    (out_vld),
        .q_dest   (out_dest),
        .q_sel    (q_sel),
        .q_wacc   (west_acc),
        .q_nacc   (north_acc)
    );

    assign sel_east  = q_sel.east;
    assign sel_south = q_sel.south;
    assign exit_vld  = q_sel.leave;
endmodule

// File: rtl/dvn_node_chk.sv
module dvn_node_chk (
    input logic clk,
    input logic rst,
    input logic slot_stb,
    input logic west_vld,
    input logic north_vld,
    input logic ctl_in_block,
    input logic ctl_out_block,
    input logic out_vld,
    input logic sel_east,
    input logic sel_south,
    input logic exit_vld,
    input logic west_acc,
    input logic north_acc
);
    AST_WEST_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (slot_stb && !rst) |=> (west_acc == $past(west_vld)));      // R2

    AST_NORTH_HELD: assert property (@(posedge clk) disable iff (rst)
        (slot_stb && !rst && west_vld) |=> !north_acc);             // R2

    AST_SOUTH_OPEN: assert property (@(posedge clk) disable iff (rst)
        (slot_stb && !rst && ctl_in_block) |=> !sel_south);         // R4

    AST_BLOCK_EAST: assert property (@(posedge clk) disable iff (rst)
        (slot_stb && !rst && ctl_out_block) |=> sel_east);          // R5

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_east, sel_south, exit_vld}));                 // R8

    AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (rst)
        (!slot_stb && !rst) |=> ($stable(out_vld) && $stable(sel_east)
                                 && $stable(exit_vld)));            // R7

    AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (slot_stb && !rst && !west_vld && !north_vld)
            |=> (!out_vld && !exit_vld && !north_acc));             // R9
endmodule

bind defl_node_ctrl dvn_node_chk u_chk (.*);

// File: tb/defl_node_ctrl_bench.sv
module defl_node_ctrl_bench;
    localparam int          HW   = 4;
    localparam int          LV_A = 1;
    localparam logic [3:0]  NH_A = 4'b0110;
    localparam int          LV_B = 4;
    localparam logic [3:0]  NH_B = 4'b1001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb = 1'b0;
    logic wv = 1'b0, nv = 1'b0, blk = 1'b0;
    logic [3:0] wd = '0, nd = '0;

    logic       co [2];
    logic       ov [2];
    logic [3:0] od [2];
    logic       se [2], ss [2], ex [2], wa [2], na [2];

    defl_node_ctrl #(.HEIGHT_W(HW), .LEVEL(LV_A), .ANGLE(2), .NODE_HEIGHT(NH_A)) u_defl_node_ctrl (
        .clk(clk), .rst(rst), .slot_stb(stb),
        .west_vld(wv), .west_dest(wd), .north_vld(nv), .north_dest(nd),
        .ctl_in_block(blk), .ctl_out_block(co[0]),
        .out_vld(ov[0]), .out_dest(od[0]), .sel_east(se[0]), .sel_south(ss[0]),
        .exit_vld(ex[0]), .west_acc(wa[0]), .north_acc(na[0]));

    defl_node_ctrl #(.HEIGHT_W(HW), .LEVEL(LV_B), .ANGLE(0), .NODE_HEIGHT(NH_B)) u_last (
        .clk(clk), .rst(rst), .slot_stb(stb),
        .west_vld(wv), .west_dest(wd), .north_vld(nv), .north_dest(nd),
        .ctl_in_block(blk), .ctl_out_block(co[1]),
        .out_vld(ov[1]), .out_dest(od[1]), .sel_east(se[1]), .sel_south(ss[1]),
        .exit_vld(ex[1]), .west_acc(wa[1]), .north_acc(na[1]));

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // model state: 0 idle, 1 east, 2 south, 3 exit
    int         m_rt [2] = '{0, 0};
    logic [3:0] m_d  [2] = '{4'd0, 4'd0};
    logic       m_wa = 1'b0, m_na = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int ref_route(logic v, logic [3:0] d, logic b, int lv, logic [3:0] nh);
        if (!v) return 0;
        if (lv >= HW) return (d == nh) ? 3 : 1;
        if (d[HW-1-lv] == nh[HW-1-lv]) return b ? 1 : 2;
        return 1;
    endfunction

    task automatic check_regs(bit was_stb);
        for (int k = 0; k < 2; k++) begin
            string t8, t3, t6;
            t8 = was_stb ? "R8" : "R7";
            t3 = !was_stb ? "R7" : (blk ? "R4" : "R3");
            t6 = was_stb ? "R6" : "R7";
            chk(t8, "out_vld", ov[k], (m_rt[k] == 1 || m_rt[k] == 2));
            chk(t8, "out_dest", od[k], (m_rt[k] == 1 || m_rt[k] == 2) ? m_d[k] : 0);
            chk(t3, "sel_east", se[k], m_rt[k] == 1);
            chk(t3, "sel_south", ss[k], m_rt[k] == 2);
            chk(t6, "exit_vld", ex[k], m_rt[k] == 3);
            chk(was_stb ? "R2" : "R7", "west_acc", wa[k], m_wa);
            chk(was_stb ? "R2" : "R7", "north_acc", na[k], m_na);
        end
    endtask

    // Called just after a falling edge
    task automatic slot(logic v1, logic [3:0] d1, logic v2, logic [3:0] d2, logic b, logic s);
        logic [3:0] dd;
        int r0, r1;
        wv = v1; wd = d1; nv = v2; nd = d2; blk = b; stb = s;
        #1;
        dd = v1 ? d1 : d2;
        r0 = ref_route(v1 || v2, dd, b, LV_A, NH_A);
        r1 = ref_route(v1 || v2, dd, b, LV_B, NH_B);
        chk((v1 || v2) ? "R5" : "R9", "ctl_out_mid", co[0], r0 == 1);
        chk((v1 || v2) ? "R5" : "R9", "ctl_out_last", co[1], r1 == 1);
        if (s) begin
            m_rt[0] = r0; m_rt[1] = r1;
            m_d[0] = dd;  m_d[1] = dd;
            m_wa = v1; m_na = v2 && !v1;
        end
        @(posedge clk);
        @(negedge clk);
        check_regs(s);
    endtask

    initial begin
        @(negedge clk);
        stb = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk("R1", "reset out_vld", ov[k], 0);
            chk("R1", "reset sel", {se[k], ss[k], ex[k]}, 0);
            chk("R1", "reset acc", {wa[k], na[k]}, 0);
        end
        rst = 1'b0; stb = 1'b0;
        @(negedge clk);
        chk("R1", "post-reset out_vld", ov[0], 0);

        // R3: bit 2 matches node -> south; other bits ignored
        slot(1, 4'b0100, 0, 4'b0000, 0, 1);
        slot(1, 4'b1111, 0, 4'b0000, 0, 1);
        slot(1, 4'b1011, 0, 4'b0000, 0, 1);
        slot(1, 4'b0000, 0, 4'b0000, 0, 1);
        // R4: blocked south deflects east
        slot(1, 4'b0101, 0, 4'b0000, 1, 1);
        // R2: both valid, west wins
        slot(1, 4'b1000, 1, 4'b0100, 0, 1);
        slot(0, 4'b0000, 1, 4'b0110, 0, 1);
        // R6: exit on innermost, mismatch circulates
        slot(0, 4'b0000, 1, 4'b1001, 0, 1);
        slot(1, 4'b1001, 0, 4'b0000, 1, 1);
        slot(1, 4'b1000, 0, 4'b0000, 0, 1);
        // R7: inputs change without strobe
        slot(1, 4'b0100, 1, 4'b1111, 0, 0);
        slot(0, 4'b0000, 1, 4'b0010, 1, 0);
        // R9: idle slot
        slot(0, 4'b1111, 0, 4'b1111, 1, 1);

        for (int i = 0; i < 400; i++) begin
            slot($urandom % 2, 4'($urandom), $urandom % 2, 4'($urandom),
                 $urandom % 2, ($urandom % 3) != 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule